// File: doc/BRIEF.md
# Power-up serial memory streamer

This block drives a shared serial data line with the contents of a small configuration array as soon as the chip leaves power-on reset. It is paced by a slow external stream clock. Before sending anything it waits out a fixed number of stream-clock rising edges with the line released. It then sends each byte most significant bit first, one bit per rising edge. After every byte comes one idle slot in which the line is released. The address steps through the array and wraps to zero forever.

A second, separate bus clock input normally sits high. Once it has been high, a low level that lasts long enough hands the data line over to a bidirectional bus mode. The streamer then releases the line and stops for good. Only a new reset brings streaming back. Both external clocks are sampled into the system clock through two-flop synchronisers. The bus clock low level must also pass a glitch filter of a programmable length. The array itself lives outside: the block presents an address and reads back a byte on the same cycle.

Top module: `boot_config_streamer`

## Requirements
- R1: While reset is held and just after it, `line_oe` is 0, `bus_mode` is 0 and `rd_addr` is 0.
- R2: During the first SYNC_EDGES rising edges of `stream_clk` after reset, `line_oe` stays 0.
- R3: Rising edge number SYNC_EDGES+1 drives `line_out` to bit 7 of the byte at address 0, with `line_oe` = 1.
- R4: Each byte takes nine rising edges of `stream_clk`. Slots 0 to 7 drive data bits 7 down to 0 with `line_oe` = 1. Slot 8 is a null bit with `line_oe` = 0, and `rd_addr` then advances by one.
- R5: After the null bit of address DEPTH-1, `rd_addr` returns to 0 and the next edge sends bit 7 of address 0 with no extra slot.
- R6: A low pulse on `bus_clk` shorter than FILTER_LEN system clocks is ignored: `bus_mode` stays 0 and streaming goes on at the same bit position.
- R7: A `bus_clk` low level held for at least FILTER_LEN system clocks, after `bus_clk` has been high, sets `bus_mode` to 1 and `line_oe` to 0 within FILTER_LEN+3 system clocks.
- R8: Once `bus_mode` is 1 it stays 1. `line_oe` stays 0 and `rd_addr` is frozen, whatever `stream_clk` and `bus_clk` do, until reset.
- R9: A reset after bus mode returns the block to streaming, and the full synchronisation period is repeated.
- R10: The outputs respond to a `stream_clk` rising edge within three system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| stream_clk | input | 1 | Slow stream pacing clock, asynchronous |
| bus_clk | input | 1 | Bus clock, asynchronous; a filtered falling edge selects bus mode |
| line_out | output | 1 | Serial data value |
| line_oe | output | 1 | Drive enable for the data line |
| rd_addr | output | ADDR_W | Array read address, also the current stream address |
| rd_data | input | DATA_W | Array byte at `rd_addr`, same cycle |
| bus_mode | output | 1 | High once the block has handed the line to bus mode |

## Verification
The bench builds the block with DEPTH = 8, FILTER_LEN = 4 and the default SYNC_EDGES = 9. With a depth of eight, every bit slot of every address can be swept across three full wraps in a few thousand cycles, so the wrap seam and the null slot are checked many times over. A filter of four makes a two-cycle glitch and a held low level easy to tell apart. The bench sets the expected bytes with a simple arithmetic formula of the address. It then checks the sticky mode, and the synchronisation period that runs again after a second reset.

// File: rtl/boot_config_streamer.sv
module boot_config_streamer #(
  parameter int DEPTH      = 128,
  parameter int DATA_W     = 8,
  parameter int SYNC_EDGES = 9,
  parameter int FILTER_LEN = 4,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int SC_W      = $clog2(SYNC_EDGES + 1),
  localparam int FC_W      = $clog2(FILTER_LEN + 1),
  localparam int SLOT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stream_clk,
  input  logic              bus_clk,
  output logic              line_out,
  output logic              line_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              bus_mode
);

  logic [2:0]        sclk_sr;
  logic [1:0]        bclk_sr;
  logic              stream_rise;
  logic              bus_low;
  logic              armed;
  logic [FC_W-1:0]   low_cnt;
  logic              bus_hit;
  logic [SC_W-1:0]   sync_cnt;
  logic              synced;
  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] addr_next;

  assign stream_rise = sclk_sr[1] & ~sclk_sr[2];
  assign bus_low     = ~bclk_sr[1];
  assign bus_hit     = armed & bus_low & (low_cnt == FC_W'(FILTER_LEN - 1));
  assign synced      = (sync_cnt == SC_W'(SYNC_EDGES));
  assign addr_next   = (rd_addr == ADDR_W'(DEPTH - 1)) ? '0 : rd_addr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr <= '0;
      bclk_sr <= 2'b11;
    end else begin
      sclk_sr <= {sclk_sr[1:0], stream_clk};
      bclk_sr <= {bclk_sr[0], bus_clk};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      low_cnt <= '0;
    end else begin
      if (!bus_low) armed <= 1'b1;
      if (!bus_low) low_cnt <= '0;
      else if (low_cnt != FC_W'(FILTER_LEN)) low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_mode <= 1'b0;
      sync_cnt <= '0;
      slot     <= '0;
      rd_addr  <= '0;
      line_out <= 1'b0;
      line_oe  <= 1'b0;
    end else if (bus_mode || bus_hit) begin
      bus_mode <= 1'b1;
      line_oe  <= 1'b0;
    end else if (stream_rise) begin
      if (!synced) begin
        sync_cnt <= sync_cnt + 1'b1;
      end else if (slot == SLOT_W'(DATA_W)) begin
        line_oe <= 1'b0;
        slot    <= '0;
        rd_addr <= addr_next;
      end else begin
        line_out <= rd_data[DATA_W-1-int'(slot)];
        line_oe  <= 1'b1;
        slot     <= slot + 1'b1;
      end
    end
  end

  a_r2_quiet_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !line_oe);

  a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |=> bus_mode);

  a_r8_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> !line_oe);

  a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |=> $stable(rd_addr));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |-> (rd_addr == (($past(rd_addr) == ADDR_W'(DEPTH - 1)) ? '0 : $past(rd_addr) + 1'b1)));

  a_r4_null_before_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |-> !line_oe);

  a_r7_mode_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_mode) |-> $past(bus_low));

endmodule

// File: tb/sim_boot_config_streamer.sv
module sim_boot_config_streamer;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int SYNC  = 9;
  localparam int FLT   = 4;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, sclk = 0, bclk = 1;
  logic line_out, line_oe, bus_mode;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  int tests = 0, fails = 0;
  int cur_b = 0, cur_k = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 37 + 11);
  endfunction

  assign rd_data = pat(int'(rd_addr));

  boot_config_streamer #(.DEPTH(DEPTH), .DATA_W(DW), .SYNC_EDGES(SYNC), .FILTER_LEN(FLT)) u0 (
    .clk(clk), .rst_n(rst_n), .stream_clk(sclk), .bus_clk(bclk),
    .line_out(line_out), .line_oe(line_oe), .rd_addr(rd_addr),
    .rd_data(rd_data), .bus_mode(bus_mode));

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10: outputs sampled three system clocks after the rising edge
  task automatic edge_up();
    @(negedge clk) sclk = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic edge_down();
    @(negedge clk) sclk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0; sclk = 0; bclk = 1;
    repeat (3) @(negedge clk);
    chk("R1 oe", line_oe == 0, line_oe, 0);
    chk("R1 mode", bus_mode == 0, bus_mode, 0);
    chk("R1 addr", rd_addr == 0, rd_addr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sync_phase();
    for (int i = 0; i < SYNC; i++) begin
      edge_up();
      chk("R2 quiet", line_oe == 0, line_oe, 0);
      edge_down();
    end
    cur_b = 0; cur_k = 0;
  endtask

  task automatic stream_slot();
    logic [DW-1:0] d;
    edge_up();
    d = pat(cur_b);
    if (cur_k < DW) begin
      chk("R4 bit", line_oe == 1 && line_out == d[DW-1-cur_k],
          {line_oe, line_out}, {1'b1, d[DW-1-cur_k]});
      chk("R4 addr hold", rd_addr == AW'(cur_b), rd_addr, cur_b);
      cur_k++;
    end else begin
      cur_b = (cur_b + 1) % DEPTH;
      chk("R4 null", line_oe == 0, line_oe, 0);
      chk("R5 addr step", rd_addr == AW'(cur_b), rd_addr, cur_b);
      cur_k = 0;
    end
    edge_down();
  endtask

  initial begin
    do_reset();
    sync_phase();
    edge_up();
    chk("R3 first bit", line_oe == 1 && line_out == pat(0)[DW-1], line_out, pat(0)[DW-1]);
    edge_down();
    cur_k = 1;
    for (int n = 0; n < 3 * DEPTH * (DW + 1) - 1; n++) stream_slot();
    // R6: short glitch on bus clock
    for (int g = 1; g < FLT; g++) begin
      @(negedge clk) bclk = 0;
      repeat (g) @(negedge clk);
      bclk = 1;
      repeat (FLT + 4) @(negedge clk);
      chk("R6 glitch ignored", bus_mode == 0, bus_mode, 0);
      stream_slot();
    end
    for (int n = 0; n < 20; n++) stream_slot();
    // R7: valid falling edge
    while (cur_k >= DW) stream_slot();
    edge_up();
    @(negedge clk) bclk = 0;
    repeat (FLT + 3) @(negedge clk);
    chk("R7 mode set", bus_mode == 1, bus_mode, 1);
    chk("R7 line released", line_oe == 0, line_oe, 0);
    edge_down();
    begin
      logic [AW-1:0] frozen;
      frozen = rd_addr;
      @(negedge clk) bclk = 1;
      for (int n = 0; n < 2 * (DW + 1); n++) begin
        edge_up();
        chk("R8 oe low", line_oe == 0, line_oe, 0);
        chk("R8 addr frozen", rd_addr == frozen, rd_addr, frozen);
        chk("R8 mode kept", bus_mode == 1, bus_mode, 1);
        edge_down();
      end
    end
    // R9: reset brings streaming back
    do_reset();
    sync_phase();
    edge_up();
    chk("R9 restart bit", line_oe == 1 && line_out == pat(0)[DW-1], line_out, pat(0)[DW-1]);
    edge_down();
    cur_k = 1;
    for (int n = 0; n < DEPTH * (DW + 1); n++) stream_slot();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule